// File: doc/BRIEF.md
# Byte-Parallel FPGA Configuration Master

This block configures an FPGA through its byte-wide slave-parallel port. When `start_load` is pulsed, it drives the program line for a fixed number of cycles. It then waits for the target to report ready, which means the init line and the busy line are both low. Bitstream bytes arrive on a valid/ready stream, and the block transfers each one with a single low-then-high pulse of the configuration clock while write-enable and chip-select are held active. When busy checking is on, the block keeps pulsing the clock while the target holds busy high. After the last byte it releases chip-select and write-enable and keeps clocking until done rises.

When `start_read` is pulsed, the block runs a readback instead. It holds chip-select with write-enable low, issues one clock pulse per byte and captures the data-in bus after each rising edge. Each captured byte goes out on a valid/ready stream. The block applies back-pressure on both streams. On the input side, `s_ready` is high only while no byte is in flight: after a byte is accepted, `s_ready` stays low until that byte's clock pulse, and any busy stall that follows, has finished. On the output side, a captured byte is held on `m_data` with `m_valid` high until `m_ready` is seen, and no further clock pulse is issued until then.

Every operation ends with a one-cycle `done_pulse` that carries a two-bit result. All waits on the target share a single timeout of `CLK_HZ/100` cycles, which is 10 ms. Edges of the configuration clock are spaced `HALF_CYC` system cycles apart.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset the outputs are idle: `cfg_prog`, `cfg_cs`, `cfg_wr`, `s_ready`, `m_valid`, `op_active` and `done_pulse` are low, and `cfg_cclk` is high.
- R2: On `start_load`, `cfg_prog` is high for exactly `PROG_CYC` cycles and is never high at the same time as `cfg_cs`. The block then waits for `cfg_init`=0 and `cfg_busy`=0. If that does not happen within the timeout, the operation ends with result 1, and `cfg_cs` and `cfg_wr` are never asserted.
- R3: `s_ready` is high only while `cfg_cs`, `cfg_wr` and `cfg_cclk` are all high. These three are set together before the first byte.
- R4: An accepted byte is driven on `cfg_dout` and stays stable through one low-then-high `cfg_cclk` pulse. With busy checking off, the target sees exactly one rising edge per byte.
- R5: `cfg_cclk` changes only on the internal edge tick, so successive changes are at least `HALF_CYC` cycles apart.
- R6: With `busy_chk_en` high, each byte's rising edge is followed by one extra clock pulse for every tick on which `cfg_busy` is still high. If `cfg_busy` stays high for the whole timeout, the operation ends with result 2 and `cfg_cs`/`cfg_wr` are released.
- R7: After the byte marked with `s_last`, `cfg_cs` and `cfg_wr` go low and `cfg_cclk` keeps pulsing until `cfg_done` is high. If done rises on the N-th pulse, exactly N pulses are issued.
- R8: `done_pulse` lasts one cycle, and `done_status` holds the result: 0 success, 1 ready timeout, 2 busy timeout, 3 done timeout. A done timeout gives result 3.
- R9: In readback, `cfg_cs` is high and `cfg_wr` is low. Each clock pulse is followed by one captured `cfg_din` byte on `m_data`, which is held with `m_valid` until `m_ready`.
- R10: A readback delivers `rd_len` bytes, with 0 treated as 1. It then drops `cfg_cs`, issues exactly one more clock pulse and ends with result 0.
- R11: With `POST_EN`=1, `post_strobe` pulses in the cycle after every `done_pulse`.
- R12: `start_load` and `start_read` are ignored while `op_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_load | input | 1 | Begin a configuration load |
| start_read | input | 1 | Begin a readback |
| busy_chk_en | input | 1 | Enable busy stalls during load (latched at start) |
| rd_len | input | LEN_W | Readback byte count (latched at start) |
| s_valid | input | 1 | Bitstream byte valid |
| s_data | input | DATA_W | Bitstream byte |
| s_last | input | 1 | Marks final bitstream byte |
| s_ready | output | 1 | Block accepts a byte |
| m_valid | output | 1 | Readback byte valid |
| m_data | output | DATA_W | Readback byte |
| m_ready | input | 1 | Consumer accepts readback byte |
| cfg_prog | output | 1 | Program request to target (1 = asserted) |
| cfg_cs | output | 1 | Chip select (1 = asserted) |
| cfg_wr | output | 1 | Write enable (1 = asserted) |
| cfg_cclk | output | 1 | Configuration clock, idles high |
| cfg_dout | output | DATA_W | Data bus toward target |
| cfg_din | input | DATA_W | Data bus from target |
| cfg_init | input | 1 | Target initialising (1 = not ready) |
| cfg_busy | input | 1 | Target busy |
| cfg_done | input | 1 | Target configured |
| op_active | output | 1 | Operation in progress |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_status | output | 2 | Result code, valid with done_pulse |
| post_strobe | output | 1 | Post-configuration strobe |

## Verification
The bench goes after the timing corners of this handshake. The program pulse length has to be exact; a design with an off-by-one on the delay load would hold program a cycle too long. The count of clock edges has to be exact too. A design that pulsed once too often after a busy stall, or checked done only after pulsing, would give the target the wrong number of rising edges, and the bench's model catches that. The bench also makes each of the three timeouts fire and checks its result code. A design that asserted chip-select without a ready target, or kept it asserted after a busy timeout, would show up at the pins. In readback, the bench stalls `m_ready`, asks for zero bytes, and counts the trailing pulse taken with chip-select low. The bench also fires start requests in the middle of a load; a design that honoured them would produce an extra completion or readback bytes.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_PROG, S_RDY,
    S_LGET, S_LLO, S_LHI, S_LBSY, S_LBHI, S_LEND,
    S_DCHK, S_DHI,
    S_RLO, S_RHI, S_RCAP, S_RWT, S_RELO, S_REHI,
    S_FIN
  } seq_st_e;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_RDY_TO = 2'd1,
    RES_BSY_TO = 2'd2,
    RES_DN_TO  = 2'd3
  } res_e;

  typedef struct packed {
    logic prog;
    logic cs;
    logic wr;
    logic cclk;
  } pins_t;

  localparam pins_t PINS_IDLE = '{prog: 1'b0, cs: 1'b0, wr: 1'b0, cclk: 1'b1};

endpackage

// File: rtl/pcl_tick.sv
// Edge-spacing divider: one tick every DIV cycles, restartable.
module pcl_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !clr;

endmodule

// File: rtl/pcl_timer.sv
// Down-counter shared by the program delay and all target timeouts.
module pcl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/pcl_seq.sv
// Operation sequencer: program, ready wait, byte load, done clocking, readback.
module pcl_seq
  import pcl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 16,
  parameter int TMR_W    = 8,
  parameter int PROG_CYC = 16,
  parameter int TO_CYC   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_load,
  input  logic              start_read,
  input  logic              busy_chk_en,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready,
  output logic              cfg_prog,
  output logic              cfg_cs,
  output logic              cfg_wr,
  output logic              cfg_cclk,
  output logic [DATA_W-1:0] cfg_dout,
  input  logic [DATA_W-1:0] cfg_din,
  input  logic              cfg_init,
  input  logic              cfg_busy,
  input  logic              cfg_done,
  input  logic              tick,
  output logic              tick_clr,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [TMR_W-1:0]  tmr_val,
  output logic              op_active,
  output logic              done_pulse,
  output logic [1:0]        done_status
);
  localparam logic [TMR_W-1:0] PROG_LD = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0] TO_LD   = TMR_W'(TO_CYC);

  seq_st_e            st, st_n;
  pins_t              pin_q, pin_n;
  logic [DATA_W-1:0]  dout_q, dout_n, mdat_q, mdat_n;
  logic               last_q, last_n, bchk_q, bchk_n, mval_q, mval_n;
  logic [LEN_W-1:0]   len_q, len_n, cnt_q, cnt_n;
  res_e               res_q, res_n;
  logic [LEN_W:0]     cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (LEN_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pin_q  <= PINS_IDLE;
      dout_q <= '0;
      mdat_q <= '0;
      last_q <= 1'b0;
      bchk_q <= 1'b0;
      mval_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
      res_q  <= RES_OK;
    end else begin
      st     <= st_n;
      pin_q  <= pin_n;
      dout_q <= dout_n;
      mdat_q <= mdat_n;
      last_q <= last_n;
      bchk_q <= bchk_n;
      mval_q <= mval_n;
      len_q  <= len_n;
      cnt_q  <= cnt_n;
      res_q  <= res_n;
    end
  end

  always_comb begin
    st_n     = st;
    pin_n    = pin_q;
    dout_n   = dout_q;
    mdat_n   = mdat_q;
    last_n   = last_q;
    bchk_n   = bchk_q;
    mval_n   = mval_q;
    len_n    = len_q;
    cnt_n    = cnt_q;
    res_n    = res_q;
    tmr_load = 1'b0;
    tmr_val  = PROG_LD;
    tick_clr = 1'b0;
    case (st)
      S_IDLE: begin
        if (start_load) begin
          pin_n.prog = 1'b1;
          bchk_n     = busy_chk_en;
          res_n      = RES_OK;
          tmr_load   = 1'b1;
          tmr_val    = PROG_LD;
          tick_clr   = 1'b1;
          st_n       = S_PROG;
        end else if (start_read) begin
          pin_n.cs = 1'b1;
          pin_n.wr = 1'b0;
          len_n    = rd_len;
          cnt_n    = '0;
          res_n    = RES_OK;
          tick_clr = 1'b1;
          st_n     = S_RLO;
        end
      end
      S_PROG: begin
        if (tmr_expired) begin
          pin_n.prog = 1'b0;
          tmr_load   = 1'b1;
          tmr_val    = TO_LD;
          st_n       = S_RDY;
        end
      end
      S_RDY: begin
        if (!cfg_init && !cfg_busy) begin
          pin_n.cs   = 1'b1;
          pin_n.wr   = 1'b1;
          pin_n.cclk = 1'b1;
          st_n       = S_LGET;
        end else if (tmr_expired) begin
          res_n = RES_RDY_TO;
          st_n  = S_FIN;
        end
      end
      S_LGET: begin
        if (s_valid) begin
          dout_n = s_data;
          last_n = s_last;
          st_n   = S_LLO;
        end
      end
      S_LLO: begin
        if (tick) begin
          pin_n.cclk = 1'b0;
          st_n       = S_LHI;
        end
      end
      S_LHI: begin
        if (tick) begin
          pin_n.cclk = 1'b1;
          if (bchk_q) begin
            tmr_load = 1'b1;
            tmr_val  = TO_LD;
            st_n     = S_LBSY;
          end else if (last_q) begin
            st_n = S_LEND;
          end else begin
            st_n = S_LGET;
          end
        end
      end
      S_LBSY: begin
        if (tmr_expired) begin
          pin_n.cs = 1'b0;
          pin_n.wr = 1'b0;
          res_n    = RES_BSY_TO;
          st_n     = S_FIN;
        end else if (tick) begin
          if (!cfg_busy) begin
            st_n = last_q ? S_LEND : S_LGET;
          end else begin
            pin_n.cclk = 1'b0;
            st_n       = S_LBHI;
          end
        end
      end
      S_LBHI: begin
        if (tick) begin
          pin_n.cclk = 1'b1;
          st_n       = S_LBSY;
        end
      end
      S_LEND: begin
        if (tick) begin
          pin_n.cs = 1'b0;
          pin_n.wr = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TO_LD;
          st_n     = S_DCHK;
        end
      end
      S_DCHK: begin
        if (cfg_done) begin
          res_n = RES_OK;
          st_n  = S_FIN;
        end else if (tmr_expired) begin
          res_n = RES_DN_TO;
          st_n  = S_FIN;
        end else if (tick) begin
          pin_n.cclk = 1'b0;
          st_n       = S_DHI;
        end
      end
      S_DHI: begin
        if (tick) begin
          pin_n.cclk = 1'b1;
          st_n       = S_DCHK;
        end
      end
      S_RLO: begin
        if (tick) begin
          pin_n.cclk = 1'b0;
          st_n       = S_RHI;
        end
      end
      S_RHI: begin
        if (tick) begin
          pin_n.cclk = 1'b1;
          st_n       = S_RCAP;
        end
      end
      S_RCAP: begin
        mdat_n = cfg_din;
        mval_n = 1'b1;
        st_n   = S_RWT;
      end
      S_RWT: begin
        if (m_ready) begin
          mval_n = 1'b0;
          cnt_n  = cnt_inc[LEN_W-1:0];
          if (cnt_inc >= {1'b0, len_q}) begin
            pin_n.cs = 1'b0;
            st_n     = S_RELO;
          end else begin
            st_n = S_RLO;
          end
        end
      end
      S_RELO: begin
        if (tick) begin
          pin_n.cclk = 1'b0;
          st_n       = S_REHI;
        end
      end
      S_REHI: begin
        if (tick) begin
          pin_n.cclk = 1'b1;
          res_n      = RES_OK;
          st_n       = S_FIN;
        end
      end
      S_FIN: begin
        pin_n = PINS_IDLE;
        st_n  = S_IDLE;
      end
      default: begin
        pin_n = PINS_IDLE;
        st_n  = S_IDLE;
      end
    endcase
  end

  assign s_ready     = (st == S_LGET);
  assign m_valid     = mval_q;
  assign m_data      = mdat_q;
  assign cfg_prog    = pin_q.prog;
  assign cfg_cs      = pin_q.cs;
  assign cfg_wr      = pin_q.wr;
  assign cfg_cclk    = pin_q.cclk;
  assign cfg_dout    = dout_q;
  assign op_active   = (st != S_IDLE);
  assign done_pulse  = (st == S_FIN);
  assign done_status = res_q;

  // R2: program and chip select never overlap
  p_prog_cs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_prog |-> !cfg_cs);

  // R3: a byte is only taken with the port set up for writing
  p_ready_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (cfg_cs && cfg_wr && cfg_cclk));

  // R4: data is steady across the transferring edge
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_cclk) && cfg_wr) |-> $stable(cfg_dout));

  // R5: clock edges only follow a divider tick
  p_edge_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk != $past(cfg_cclk)) |-> $past(tick));

  // R7: done clocking happens with the port released
  p_done_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DCHK || st == S_DHI) |-> (!cfg_cs && !cfg_wr));

  // R8: completion strobe is a single cycle
  p_done_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R9: readback byte held under back-pressure, never while writing
  p_mhold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  p_rb_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (cfg_cs && !cfg_wr));

  // R12: a start during an operation does not restart programming
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && !done_pulse && (start_load || start_read)) |=> !$rose(cfg_prog));

endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int HALF_CYC = 4,
  parameter int PROG_CYC = 16,
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 16,
  parameter bit POST_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_load,
  input  logic              start_read,
  input  logic              busy_chk_en,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready,
  output logic              cfg_prog,
  output logic              cfg_cs,
  output logic              cfg_wr,
  output logic              cfg_cclk,
  output logic [DATA_W-1:0] cfg_dout,
  input  logic [DATA_W-1:0] cfg_din,
  input  logic              cfg_init,
  input  logic              cfg_busy,
  input  logic              cfg_done,
  output logic              op_active,
  output logic              done_pulse,
  output logic [1:0]        done_status,
  output logic              post_strobe
);
  localparam int TO_CYC = CLK_HZ / 100;
  localparam int MAX_LD = (TO_CYC > PROG_CYC) ? TO_CYC : PROG_CYC;
  localparam int TMR_W  = $clog2(MAX_LD + 1);

  logic             tick, tick_clr, tmr_expired, tmr_load;
  logic [TMR_W-1:0] tmr_val;

  pcl_tick #(.DIV(HALF_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
  );

  pcl_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_expired)
  );

  pcl_seq #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .TMR_W(TMR_W),
    .PROG_CYC(PROG_CYC), .TO_CYC(TO_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_load(start_load), .start_read(start_read),
    .busy_chk_en(busy_chk_en), .rd_len(rd_len),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .cfg_prog(cfg_prog), .cfg_cs(cfg_cs), .cfg_wr(cfg_wr), .cfg_cclk(cfg_cclk),
    .cfg_dout(cfg_dout), .cfg_din(cfg_din),
    .cfg_init(cfg_init), .cfg_busy(cfg_busy), .cfg_done(cfg_done),
    .tick(tick), .tick_clr(tick_clr),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .op_active(op_active), .done_pulse(done_pulse), .done_status(done_status)
  );

  generate
    if (POST_EN) begin : g_post
      logic post_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) post_q <= 1'b0;
        else        post_q <= done_pulse;
      end
      assign post_strobe = post_q;

      // R11: post strobe follows every completion
      p_post_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> post_strobe);
    end else begin : g_nopost
      assign post_strobe = 1'b0;
    end
  endgenerate

endmodule

// File: tb/sim_cfg_par_loader.sv
`timescale 1ns/1ps
module sim_cfg_par_loader;
  localparam int HALF = 2;
  localparam int PROG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start_load = 0, start_read = 0, busy_chk_en = 0;
  logic [15:0] rd_len = '0;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, cfg_prog, cfg_cs, cfg_wr, cfg_cclk;
  logic op_active, done_pulse, post_strobe;
  logic [7:0] m_data, cfg_dout, cfg_din;
  logic [1:0] done_status;
  logic cfg_init = 0, cfg_busy, cfg_done;

  cfg_par_loader #(.CLK_HZ(100_000), .HALF_CYC(HALF), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_read(start_read),
    .busy_chk_en(busy_chk_en), .rd_len(rd_len),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .cfg_prog(cfg_prog), .cfg_cs(cfg_cs), .cfg_wr(cfg_wr), .cfg_cclk(cfg_cclk),
    .cfg_dout(cfg_dout), .cfg_din(cfg_din), .cfg_init(cfg_init),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .op_active(op_active),
    .done_pulse(done_pulse), .done_status(done_status), .post_strobe(post_strobe)
  );

  int checks = 0, failures = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  bit init_stuck = 0, busy_stick = 0, model_chk = 0;
  int busy_len = 0, busy_cnt = 0, dn_target = 0, tail = 0, rises_ld = 0, nrx = 0, init_cnt = 0;
  logic [7:0] rx [0:63];
  logic [7:0] rb_val = 8'h40;

  assign cfg_busy = busy_stick ? (nrx >= 1) : (busy_cnt != 0);
  assign cfg_done = (tail >= dn_target);
  assign cfg_din  = rb_val;

  always @(posedge clk) begin
    if (cfg_prog) begin cfg_init <= 1'b1; init_cnt <= 5; end
    else if (init_cnt != 0) init_cnt <= init_cnt - 1;
    else cfg_init <= init_stuck;
  end

  always @(posedge cfg_cclk) begin
    if (cfg_cs && cfg_wr) begin
      rises_ld <= rises_ld + 1;
      if (!model_chk || busy_cnt == 0) begin
        if (nrx < 64) rx[nrx] <= cfg_dout;
        nrx <= nrx + 1;
      end
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      else if (busy_len > 0 && (nrx % 2) == 0) busy_cnt <= busy_len;
    end
    if (!cfg_cs) tail <= tail + 1;
    if (cfg_cs && !cfg_wr) rb_val <= rb_val + 8'd1;
  end

  // ---------------- monitors ----------------
  int n_done = 0, n_post = 0, last_stat = 0, prog_run = 0, prog_len = 0;
  int gap = 0, min_gap = 1000, bad_ready = 0, m_seen = 0, cs_seen = 0, wr_in_rb = 0;
  int cyc = 0;
  logic prev_cclk = 1'b1;
  bit rb_mode = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done_pulse) begin n_done <= n_done + 1; last_stat <= int'(done_status); end
    if (post_strobe) n_post <= n_post + 1;
    if (cfg_prog) prog_run <= prog_run + 1;
    else if (prog_run != 0) begin prog_len <= prog_run; prog_run <= 0; end
    if (cfg_cclk != prev_cclk) begin
      if (gap + 1 < min_gap) min_gap <= gap + 1;
      gap <= 0;
    end else gap <= gap + 1;
    prev_cclk <= cfg_cclk;
    if (s_ready && !(cfg_cs && cfg_wr && cfg_cclk)) bad_ready <= bad_ready + 1;
    if (m_valid) m_seen <= m_seen + 1;
    if (cfg_cs) cs_seen <= cs_seen + 1;
    if (rb_mode && cfg_wr) wr_in_rb <= wr_in_rb + 1;
  end

  // readback consumer with stalls
  int nrb = 0;
  logic [7:0] rb [0:63];
  always @(negedge clk) begin
    m_ready = rb_mode && ((cyc % 3) != 0);
    if (m_valid && m_ready) begin
      if (nrb < 64) rb[nrb] = m_data;
      nrb = nrb + 1;
    end
  end

  bit wd = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd = 1;
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] pat(input int i);
    return 8'hA0 ^ 8'(i * 37);
  endfunction

  task automatic model_clear();
    @(negedge clk);
    nrx = 0; rises_ld = 0; tail = 0; busy_cnt = 0; min_gap = 1000; gap = 0;
    bad_ready = 0; m_seen = 0; cs_seen = 0; nrb = 0; wr_in_rb = 0;
  endtask

  task automatic wait_done(input int n0, input string tag);
    int k = 0;
    while (n_done == n0 && k < 20000 && !wd) begin @(negedge clk); k++; end
    chk(n_done != n0, tag, n_done, n0 + 1);
    @(negedge clk);
  endtask

  task automatic send_bytes(input int n, input int n0, input int mid_start);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = pat(i); s_last = (i == n - 1);
      while (!s_ready && n_done == n0 && !wd) @(negedge clk);
      if (n_done != n0 || wd) begin s_valid = 0; s_last = 0; return; end
      @(negedge clk);
      s_valid = 0; s_last = 0;
      if (i == mid_start) begin
        start_read = 1; start_load = 1; rd_len = 16'd3;
        @(negedge clk);
        start_read = 0; start_load = 0;
      end
    end
  endtask

  task automatic pulse_load(input bit chk_en);
    @(negedge clk);
    busy_chk_en = chk_en; start_load = 1;
    @(negedge clk);
    start_load = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(!cfg_prog && !cfg_cs && !cfg_wr && cfg_cclk, "R1 port idle", {cfg_prog, cfg_cs, cfg_wr, cfg_cclk}, 1);
    chk(!s_ready && !m_valid && !op_active && !done_pulse, "R1 streams idle",
        {s_ready, m_valid, op_active, done_pulse}, 0);
  endtask

  task automatic t_load_plain();
    int n0;
    model_clear(); model_chk = 0; busy_len = 0; dn_target = 3;
    n0 = n_done;
    pulse_load(1'b0);
    send_bytes(6, n0, -1);
    wait_done(n0, "R8 load completes");
    chk(prog_len == PROG, "R2 program length", prog_len, PROG);
    chk(nrx == 6, "R4 bytes received", nrx, 6);
    for (int i = 0; i < 6; i++) chk(rx[i] == pat(i), "R4 byte value", int'(rx[i]), int'(pat(i)));
    chk(rises_ld == 6, "R4 one edge per byte", rises_ld, 6);
    chk(tail == 3, "R7 done-phase pulses", tail, 3);
    chk(last_stat == 0, "R8 success code", last_stat, 0);
    chk(min_gap >= HALF, "R5 edge spacing", min_gap, HALF);
    chk(bad_ready == 0, "R3 ready only with port set", bad_ready, 0);
    chk(n_post == n_done, "R11 post strobe count", n_post, n_done);
    chk(!cfg_cs && !cfg_wr && !op_active, "R7 port released", {cfg_cs, cfg_wr, op_active}, 0);
  endtask

  task automatic t_load_busy();
    int n0;
    model_clear(); model_chk = 1; busy_len = 2; dn_target = 2;
    n0 = n_done;
    pulse_load(1'b1);
    send_bytes(5, n0, -1);
    wait_done(n0, "R6 busy load completes");
    chk(nrx == 5, "R6 bytes received", nrx, 5);
    for (int i = 0; i < 5; i++) chk(rx[i] == pat(i), "R6 byte value", int'(rx[i]), int'(pat(i)));
    chk(rises_ld == 11, "R6 extra busy pulses", rises_ld, 11);
    chk(last_stat == 0, "R6 status", last_stat, 0);
    busy_len = 0; model_chk = 0;
  endtask

  task automatic t_busy_ignored();
    int n0;
    model_clear(); model_chk = 0; busy_len = 1; dn_target = 1;
    n0 = n_done;
    pulse_load(1'b0);
    send_bytes(4, n0, -1);
    wait_done(n0, "R4 busy ignored completes");
    chk(rises_ld == 4, "R4 no stall when check off", rises_ld, 4);
    busy_len = 0;
  endtask

  task automatic t_busy_timeout();
    int n0;
    model_clear(); model_chk = 1; busy_stick = 1; dn_target = 1;
    n0 = n_done;
    pulse_load(1'b1);
    send_bytes(3, n0, -1);
    wait_done(n0, "R6 busy timeout completes");
    chk(last_stat == 2, "R6 busy timeout code", last_stat, 2);
    chk(!cfg_cs && !cfg_wr, "R6 port released", {cfg_cs, cfg_wr}, 0);
    busy_stick = 0; model_chk = 0;
  endtask

  task automatic t_ready_timeout();
    int n0;
    model_clear(); init_stuck = 1;
    n0 = n_done;
    pulse_load(1'b0);
    wait_done(n0, "R2 ready timeout completes");
    chk(last_stat == 1, "R2 ready timeout code", last_stat, 1);
    chk(cs_seen == 0, "R2 no chip select", cs_seen, 0);
    init_stuck = 0;
  endtask

  task automatic t_done_timeout();
    int n0;
    model_clear(); dn_target = 100000;
    n0 = n_done;
    pulse_load(1'b0);
    send_bytes(2, n0, -1);
    wait_done(n0, "R8 done timeout completes");
    chk(last_stat == 3, "R8 done timeout code", last_stat, 3);
  endtask

  task automatic t_read(input int len, input int exp_n);
    int n0;
    logic [7:0] base;
    model_clear(); dn_target = 100000;
    base = rb_val;
    rb_mode = 1;
    n0 = n_done;
    @(negedge clk);
    rd_len = 16'(len); start_read = 1;
    @(negedge clk);
    start_read = 0;
    wait_done(n0, "R10 readback completes");
    rb_mode = 0;
    chk(nrb == exp_n, "R10 readback count", nrb, exp_n);
    for (int i = 0; i < exp_n; i++)
      chk(rb[i] == base + 8'(i + 1), "R9 readback byte", int'(rb[i]), int'(base + 8'(i + 1)));
    chk(wr_in_rb == 0, "R9 write low in readback", wr_in_rb, 0);
    chk(tail == 1, "R10 trailing pulse", tail, 1);
    chk(last_stat == 0, "R10 status", last_stat, 0);
  endtask

  task automatic t_ignore_start();
    int n0;
    model_clear(); dn_target = 2;
    n0 = n_done;
    pulse_load(1'b0);
    send_bytes(4, n0, 1);
    wait_done(n0, "R12 load completes");
    repeat (40) @(negedge clk);
    chk(n_done == n0 + 1, "R12 single completion", n_done, n0 + 1);
    chk(m_seen == 0, "R12 no readback started", m_seen, 0);
    chk(nrx == 4 && rx[3] == pat(3), "R12 load intact", nrx, 4);
    chk(!op_active, "R12 idle after", op_active, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    if (!wd) t_load_plain();
    if (!wd) t_load_busy();
    if (!wd) t_busy_ignored();
    if (!wd) t_busy_timeout();
    if (!wd) t_ready_timeout();
    if (!wd) t_done_timeout();
    if (!wd) t_read(5, 5);
    if (!wd) t_read(0, 1);
    if (!wd) t_ignore_start();
    chk(n_post == n_done, "R11 post strobe total", n_post, n_done);
    if (wd) chk(1'b0, "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule